// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the software-visible configuration store of a clock control unit: twenty-six 32-bit word registers behind a simple byte-addressed bus occupying a 4 KB window. The word index is the byte address shifted right by two, and only word-aligned accesses are legal. Every register comes out of reset with its own image. A subset accepts writes, each through its own bit mask. The control register at index 0 additionally forces one configuration bit to one on every write. The remaining registers are read-only from the bus.

Reads are registered: the data for a read request appears on `rd_data` one clock after the request and holds until the next read. Illegal accesses raise `err` combinationally during the same cycle as the offending request and change no state. Illegal accesses are misaligned ones, reads past the last register, and writes to any register that is not writable. The block generates no clocks and drives nothing from register contents besides the read port.

Word indices, in order: 0 control, 1 post-divider A, 2 post-divider B, 3 reset status, 4 main PLL, 5 USB PLL, 6 serial PLL, 7 clock-out select, 8–10 gating 0–2, 11 wake mask, 12–25 status and power registers.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, the registers hold these values: 0=0x074b0b7d, 1=0xff870b48, 2=0x49fcfe7f, 3=0x007f0000, 4=0x04001800, 5=0x04051c03, 6=0x04043001, 7=0x00000280, 8..11=0xffffffff, 18=0x00004040, 23=0x80209828, 24=0x00aa0000, 25=0x00000285. All other indices hold 0. `rd_data` is 0 in reset.
- R2: A read with `rd_en` high at clock edge N puts the addressed word on `rd_data` after edge N. `rd_data` keeps its value across cycles with `rd_en` low.
- R3: A legal write to index 0 stores `wr_data & 0x3b6fdfff`, with bit FORCE_BIT (default 2) set to one.
- R4: A legal write to index 1 stores `wr_data & 0xff9f3fff`. A legal write to index 4 or 6 stores `wr_data & 0xbfff3fff`.
- R5: A legal write to index 2, 8, 9 or 10 stores all 32 bits of `wr_data`.
- R6: A write to any other index below 26 (for example 3, 5, 7, 11, 25) raises `err` and changes no register.
- R7: A read at word index 26 or above returns 0 on `rd_data` and raises `err`. A write there raises `err` and changes no register.
- R8: An access with `addr[1:0]` not equal to 0 raises `err`. Such a write changes nothing, and such a read returns 0.
- R9: `err` is high only in a cycle carrying an illegal request. It is low when idle and for legal reads and writes.
- R10: With `rd_en` and `wr_en` both high to the same legal address, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address within the 4 KB window |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | Illegal-access strobe, same cycle as the request |

## Verification
The bench writes all-ones and then all-zeros into every index and reads each value back. A wrong per-register mask shows up as stray or missing bits. Forgetting the forced bit leaves index 0 reading zero after the all-zeros write. A writable read-only register shows its written pattern instead of its reset image. Out-of-range and misaligned accesses are checked for a zero read and an error strobe, because a decoder that truncates the index would alias them onto real registers. A simultaneous read and write is checked for the pre-write value, which catches a read path wrongly taken after the register update.

// File: rtl/clkctl_regbank_pkg.sv
package clkctl_regbank_pkg;

    localparam int CCB_NREG = 26;
    localparam int CCB_DW   = 32;
    localparam int CCB_AW   = 12;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    function automatic logic [31:0] reg_reset(input int i);
        case (i)
            0:  return 32'h074b0b7d;
            1:  return 32'hff870b48;
            2:  return 32'h49fcfe7f;
            3:  return 32'h007f0000;
            4:  return 32'h04001800;
            5:  return 32'h04051c03;
            6:  return 32'h04043001;
            7:  return 32'h00000280;
            8, 9, 10, 11: return 32'hffffffff;
            18: return 32'h00004040;
            23: return 32'h80209828;
            24: return 32'h00aa0000;
            25: return 32'h00000285;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] reg_mask(input int i);
        case (i)
            0:        return 32'h3b6fdfff;
            1:        return 32'hff9f3fff;
            4, 6:     return 32'hbfff3fff;
            default:  return 32'hffffffff;
        endcase
    endfunction

    function automatic bit reg_writable(input int i);
        case (i)
            0, 1, 2, 4, 6, 8, 9, 10: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic [CCB_NREG-1:0] writable_map();
        logic [CCB_NREG-1:0] m;
        for (int i = 0; i < CCB_NREG; i++) m[i] = reg_writable(i);
        return m;
    endfunction

endpackage

// File: rtl/clkctl_addr_decode.sv
module clkctl_addr_decode
    import clkctl_regbank_pkg::*;
#(
    parameter int NREG = CCB_NREG,
    parameter int AW   = CCB_AW,
    localparam int IW  = AW - 2,
    localparam int SW  = $clog2(NREG)
) (
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    output logic [SW-1:0] sel,
    output logic          hit,
    output logic          wr_ok,
    output logic          err
);
    localparam logic [IW-1:0]   NREG_W = IW'(NREG);
    localparam logic [NREG-1:0] WR_MAP = writable_map();

    logic [IW-1:0] widx;
    logic          aligned;
    acc_e          acc;

    assign widx    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign sel     = widx[SW-1:0];
    assign hit     = aligned && (widx < NREG_W);
    assign wr_ok   = hit && WR_MAP[sel];
    assign acc     = acc_e'({wr_en, rd_en});

    always_comb begin
        unique case (acc)
            ACC_IDLE:  err = 1'b0;
            ACC_READ:  err = !hit;
            ACC_WRITE: err = !wr_ok;
            ACC_BOTH:  err = !wr_ok;
            default:   err = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkctl_reg_slot.sv
module clkctl_reg_slot #(
    parameter int          DW        = 32,
    parameter logic [31:0] RESET     = 32'h0,
    parameter logic [31:0] MASK      = 32'hffffffff,
    parameter bit          FORCE_EN  = 1'b0,
    parameter int          FORCE_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] FORCE_VAL = FORCE_EN ? (DW'(1) << FORCE_BIT) : '0;
    localparam logic [DW-1:0] MASK_W    = DW'(MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= DW'(RESET);
        else if (we) q <= (wd & MASK_W) | FORCE_VAL;
    end
endmodule

// File: rtl/clkctl_read_port.sv
module clkctl_read_port #(
    parameter int NREG = 26,
    parameter int DW   = 32,
    localparam int SW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic                     hit,
    input  logic [SW-1:0]            sel,
    input  logic [NREG-1:0][DW-1:0]  bank,
    output logic [DW-1:0]            rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= hit ? bank[sel] : '0;
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_regbank_pkg::*;
#(
    parameter int NREG      = CCB_NREG,
    parameter int DW        = CCB_DW,
    parameter int AW        = CCB_AW,
    parameter int FORCE_BIT = 2,
    localparam int SW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          err
);
    logic [SW-1:0]           sel;
    logic                    hit;
    logic                    wr_ok;
    logic [NREG-1:0][DW-1:0] bank_q;

    clkctl_addr_decode #(.NREG(NREG), .AW(AW)) u_dec (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .sel   (sel),
        .hit   (hit),
        .wr_ok (wr_ok),
        .err   (err)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (reg_writable(i)) begin : g_rw
            clkctl_reg_slot #(
                .DW        (DW),
                .RESET     (reg_reset(i)),
                .MASK      (reg_mask(i)),
                .FORCE_EN  (i == 0),
                .FORCE_BIT (FORCE_BIT)
            ) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_en && wr_ok && (sel == SW'(i))),
                .wd    (wr_data),
                .q     (bank_q[i])
            );
        end else begin : g_ro
            assign bank_q[i] = DW'(reg_reset(i));
        end
    end

    clkctl_read_port #(.NREG(NREG), .DW(DW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .hit     (hit),
        .sel     (sel),
        .bank    (bank_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int NREG      = 26,
    parameter int DW        = 32,
    parameter int AW        = 12,
    parameter int FORCE_BIT = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           addr,
    input logic                    rd_en,
    input logic                    wr_en,
    input logic [DW-1:0]           rd_data,
    input logic                    err,
    input logic [NREG-1:0][DW-1:0] bank_q
);
    localparam logic [AW-3:0] NREG_W = (AW-2)'(NREG);

    // R9: no strobe without a request
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |-> !err);

    // R7: reads past the last register
    a_r7_oob_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[AW-1:2] >= NREG_W) |-> err);
    a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[AW-1:2] >= NREG_W) |=> (rd_data == '0));

    // R8: misaligned accesses
    a_r8_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr[1:0] != 2'b00) |-> err);

    // R6: faulty writes leave the bank untouched
    a_r6_fault_nochange: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && err) |=> $stable(bank_q));
    a_r6_ro_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(3*4)) |-> err);

    // R2: read data holds while no read
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R3: forced bit after a write to index 0
    a_r3_force: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> bank_q[0][FORCE_BIT]);

    // R9: bank only moves on a write
    a_r9_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));
endmodule

bind clkctl_regbank clkctl_regbank_chk #(
    .NREG(NREG), .DW(DW), .AW(AW), .FORCE_BIT(FORCE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .err(err), .bank_q(bank_q)
);

// File: tb/clkctl_regbank_test.sv
module clkctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t scb[$];
    logic [31:0] model [26];
    bit rd_seen = 0;

    always #10 clk = ~clk;

    clkctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .err(err)
    );

    function automatic logic [31:0] init_val(input int i);
        case (i)
            0: return 32'h074b0b7d;  1: return 32'hff870b48;
            2: return 32'h49fcfe7f;  3: return 32'h007f0000;
            4: return 32'h04001800;  5: return 32'h04051c03;
            6: return 32'h04043001;  7: return 32'h00000280;
            8, 9, 10, 11: return 32'hffffffff;
            18: return 32'h00004040; 23: return 32'h80209828;
            24: return 32'h00aa0000; 25: return 32'h00000285;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3";
            1, 4, 6: return "R4";
            2, 8, 9, 10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per read seen at the previous edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rst_n && rd_seen) begin
            if (scb.size() == 0) check("R2 scoreboard empty", 32'h1, 32'h0);
            else begin
                exp_t e;
                e = scb.pop_front();
                check(e.tag, rd_data, e.val);
            end
        end
    end

    task automatic access(input bit rd, input bit wr, input logic [11:0] a,
                          input logic [31:0] d, input string tag);
        int  idx;
        bit  legal_rd;
        bit  legal_wr;
        exp_t e;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wr_data = d;
        idx = int'(a >> 2);
        legal_rd = (a[1:0] == 2'b00) && idx < 26;
        legal_wr = legal_rd && (idx inside {0, 1, 2, 4, 6, 8, 9, 10});
        #2;
        check({tag, " err"}, {31'b0, err},
              {31'b0, (rd && !legal_rd) || (wr && !legal_wr)});
        if (rd) begin
            e.val = legal_rd ? model[idx] : 32'h0;
            e.tag = tag;
            scb.push_back(e);
        end
        if (wr && legal_wr) begin
            case (idx)
                0: model[idx] = (d & 32'h3b6fdfff) | 32'h4;
                1: model[idx] = d & 32'hff9f3fff;
                4, 6: model[idx] = d & 32'hbfff3fff;
                default: model[idx] = d;
            endcase
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        #2;
        check("R9 idle err", {31'b0, err}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 26; i++) model[i] = init_val(i);
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        idle();

        // R1: every reset image
        for (int i = 0; i < 26; i++) access(1, 0, 12'(i*4), 0, "R1");
        idle();

        // R3 R4 R5 R6: all-ones then all-zeros per index
        for (int i = 0; i < 26; i++) begin
            access(0, 1, 12'(i*4), 32'hffffffff, tag_of(i));
            access(1, 0, 12'(i*4), 0, tag_of(i));
            access(0, 1, 12'(i*4), 32'h0, tag_of(i));
            access(1, 0, 12'(i*4), 0, tag_of(i));
        end
        idle();

        // R7: out of range
        access(1, 0, 12'(26*4), 0, "R7");
        access(1, 0, 12'hffc, 0, "R7");
        access(0, 1, 12'(26*4), 32'h12345678, "R7");
        access(0, 1, 12'(32*4 + 8), 32'h12345678, "R7");
        access(1, 0, 12'(2*4), 0, "R7");

        // R8: misaligned
        access(0, 1, 12'(2*4 + 1), 32'hdeadbeef, "R8");
        access(0, 1, 12'(9*4 + 2), 32'hdeadbeef, "R8");
        access(1, 0, 12'(2*4), 0, "R8");
        access(1, 0, 12'(9*4), 0, "R8");
        access(1, 0, 12'(1*4 + 3), 0, "R8");

        // R10: read and write together
        access(0, 1, 12'(9*4), 32'ha5a5a5a5, "R10");
        access(1, 1, 12'(9*4), 32'h5a5a5a5a, "R10");
        access(1, 0, 12'(9*4), 0, "R10");
        access(1, 1, 12'(0*4), 32'h0, "R10");
        access(1, 0, 12'(0*4), 0, "R10");

        // R2: hold across idle cycles
        access(1, 0, 12'(23*4), 0, "R2");
        idle(); idle(); idle();
        check("R2 hold", rd_data, init_val(23));

        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", 32'(scb.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule